// File: doc/BRIEF.md
# Parameter-Sector Erase Address Resolver

This block sits in a serial NOR flash controller model for a 32 Mbit array. It takes an erase command, already pulled out of the serial stream, and turns it into a start address and a byte length for the erase engine. A request carries an opcode and a 24-bit byte address. It is judged against two configuration inputs. One enables the small-sector partition. The other chooses whether that 128 KB partition sits at the top or at the bottom of the array.

The legacy 64 KB erase always works on 64 KB blocks, even inside the partition. Two further opcodes erase one 4 KB sector or an 8 KB-aligned pair of 4 KB sectors, and they act only inside the partition. Each request ends in exactly one of three outcomes: it starts an erase, it is ignored, or it is rejected. The block keeps a write-enable latch and a busy flag. The busy flag opens when an erase starts and closes on a done pulse from the erase engine.

Top module: `er_resolver`

## Requirements
- R1: After reset, `busy`, `wel`, `erase_start`, `erase_ignored` and `erase_rejected` are all 0.
- R2: Opcode D8h, when accepted, gives `erase_addr` equal to the request address with bits 15:0 cleared and `erase_len` = 65536. This holds whether or not the address falls inside the small-sector partition.
- R3: Opcode 20h, when accepted, gives `erase_addr` equal to the request address with bits 11:0 cleared and `erase_len` = 4096.
- R4: Opcode 40h, when accepted, gives `erase_addr` equal to the request address with bits 12:0 cleared and `erase_len` = 8192.
- R5: The small-sector partition is the 128 KB region where address bits 21:17 are all ones when `cfg_top_param`=1 (0x3E0000–0x3FFFFF). When `cfg_top_param`=0 it is the region where those bits are all zeros (0x000000–0x01FFFF).
- R6: An in-array 20h or 40h request that lies outside the partition, or that arrives while `cfg_param_en`=0, pulses `erase_ignored`. It starts no erase and leaves `wel` unchanged.
- R7: Opcodes C7h and 60h both erase the whole array: `erase_addr` = 0 and `erase_len` = 4194304, whatever the request address.
- R8: An erase is accepted only while `wel`=1, and `wel` is set by a `wren_set` pulse. A request made while `wel`=0 pulses `erase_rejected`. An accepted erase clears `wel`, and this takes priority over a `wren_set` pulse in the same cycle.
- R9: `busy` rises together with `erase_start`. Any request made while `busy`=1 pulses `erase_rejected`. An `erase_done` pulse while busy drops `busy` on the next cycle.
- R10: An opcode other than D8h, 20h, 40h, C7h or 60h is rejected. So is a D8h, 20h or 40h request whose address bits 23:22 are not both zero, because it lies beyond the 4 MB array. A rejection does not change `wel`.
- R11: The outcome appears one cycle after the request as a one-cycle pulse, and at most one of `erase_start`, `erase_ignored` and `erase_rejected` is high at a time. `erase_addr` and `erase_len` hold their values until the next accepted erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle strobe marking an erase request |
| req_opcode | input | 8 | Erase opcode |
| req_addr | input | 24 | Byte address of the request |
| cfg_top_param | input | 1 | 1 places the small-sector partition at the top of the array, 0 at the bottom |
| cfg_param_en | input | 1 | Enables the small-sector erase opcodes |
| wren_set | input | 1 | Pulse that sets the write-enable latch |
| erase_done | input | 1 | Pulse from the erase engine that ends the busy period |
| erase_start | output | 1 | One-cycle pulse: an erase begins |
| erase_addr | output | 24 | Start address of the latest accepted erase |
| erase_len | output | 23 | Byte length of the latest accepted erase |
| erase_ignored | output | 1 | One-cycle pulse: small-sector request ignored |
| erase_rejected | output | 1 | One-cycle pulse: request rejected |
| wel | output | 1 | Write-enable latch |
| busy | output | 1 | An erase is in progress |

## Verification
Each erase opcode is tried with addresses that have nonzero bits both below and above its granularity. A wrong mask width therefore shows up as a wrong start address. The same 64 KB and 4 KB requests are then issued with the partition at the top and at the bottom, and with small sectors disabled. This separates the partition-membership test from the block-erase path, which must ignore it. Further patterns cover a missing write enable, a request during busy, an unknown opcode and an address beyond the array. Together they show which gate rejected the request and confirm that the latch survives a refusal but not an accepted erase.

// File: rtl/er_pkg.sv
package er_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_BLOCK,
    K_SMALL1,
    K_SMALL2,
    K_BULK
  } kind_t;

  typedef enum logic [1:0] {
    V_GO,
    V_IGNORE,
    V_REJECT
  } verdict_t;

  // Clear the low 'sh' bits of an address.
  function automatic logic [31:0] clear_low(input logic [31:0] a, input int unsigned sh);
    return (a >> sh) << sh;
  endfunction

  // Byte span of an erase unit of 2**sh bytes.
  function automatic logic [31:0] span_of(input int unsigned sh);
    return 32'd1 << sh;
  endfunction

endpackage

// File: rtl/er_decode.sv
module er_decode
  import er_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int ARRAY_LOG2 = 22,
  parameter int PART_LOG2  = 17,
  parameter int SMALL_LOG2 = 12,
  parameter int BLOCK_LOG2 = 16,
  localparam int LEN_W     = ARRAY_LOG2 + 1
) (
  input  logic [7:0]        opcode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              top_sel,
  output kind_t             kind,
  output logic              in_array,
  output logic              in_part,
  output logic [ADDR_W-1:0] base,
  output logic [LEN_W-1:0]  span
);

  logic [ARRAY_LOG2-PART_LOG2-1:0] region_idx;
  int unsigned                     gran;

  assign region_idx = addr[ARRAY_LOG2-1:PART_LOG2];
  assign in_part    = top_sel ? (&region_idx) : ~(|region_idx);
  assign in_array   = ((32'(addr) >> ARRAY_LOG2) == 32'd0);

  always_comb begin
    unique case (opcode)
      8'hD8:        kind = K_BLOCK;
      8'h20:        kind = K_SMALL1;
      8'h40:        kind = K_SMALL2;
      8'hC7, 8'h60: kind = K_BULK;
      default:      kind = K_NONE;
    endcase
  end

  always_comb begin
    case (kind)
      K_SMALL1: gran = SMALL_LOG2;
      K_SMALL2: gran = SMALL_LOG2 + 1;
      K_BULK:   gran = ARRAY_LOG2;
      default:  gran = BLOCK_LOG2;
    endcase
    span = LEN_W'(span_of(gran));
    base = (kind == K_BULK) ? '0 : ADDR_W'(clear_low(32'(addr), gran));
  end

endmodule

// File: rtl/er_track.sv
module er_track (
  input  logic clk,
  input  logic rst_n,
  input  logic wren_set,
  input  logic go,
  input  logic done,
  output logic wel,
  output logic busy
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      busy <= 1'b0;
    end else begin
      if (go)            wel <= 1'b0;
      else if (wren_set) wel <= 1'b1;
      if (go)            busy <= 1'b1;
      else if (done)     busy <= 1'b0;
    end
  end

endmodule

// File: rtl/er_resolver.sv
module er_resolver
  import er_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int ARRAY_LOG2 = 22,
  parameter int PART_LOG2  = 17,
  parameter int SMALL_LOG2 = 12,
  parameter int BLOCK_LOG2 = 16,
  localparam int LEN_W     = ARRAY_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [7:0]        req_opcode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cfg_top_param,
  input  logic              cfg_param_en,
  input  logic              wren_set,
  input  logic              erase_done,
  output logic              erase_start,
  output logic [ADDR_W-1:0] erase_addr,
  output logic [LEN_W-1:0]  erase_len,
  output logic              erase_ignored,
  output logic              erase_rejected,
  output logic              wel,
  output logic              busy
);

  kind_t             kind;
  logic              in_array;
  logic              in_part;
  logic [ADDR_W-1:0] base;
  logic [LEN_W-1:0]  span;
  verdict_t          verdict;

  // Named events for the checker.
  logic go;
  logic ign;
  logic rej;

  er_decode #(
    .ADDR_W(ADDR_W), .ARRAY_LOG2(ARRAY_LOG2), .PART_LOG2(PART_LOG2),
    .SMALL_LOG2(SMALL_LOG2), .BLOCK_LOG2(BLOCK_LOG2)
  ) u_decode (
    .opcode(req_opcode), .addr(req_addr), .top_sel(cfg_top_param),
    .kind(kind), .in_array(in_array), .in_part(in_part),
    .base(base), .span(span)
  );

  // Gate order: latch/busy, opcode, array range, partition.
  always_comb begin
    if (!wel || busy) verdict = V_REJECT;
    else begin
      case (kind)
        K_BULK:  verdict = V_GO;
        K_BLOCK: verdict = in_array ? V_GO : V_REJECT;
        K_SMALL1, K_SMALL2: begin
          if (!in_array)                    verdict = V_REJECT;
          else if (!cfg_param_en || !in_part) verdict = V_IGNORE;
          else                              verdict = V_GO;
        end
        default: verdict = V_REJECT;
      endcase
    end
  end

  assign go  = req_valid && (verdict == V_GO);
  assign ign = req_valid && (verdict == V_IGNORE);
  assign rej = req_valid && (verdict == V_REJECT);

  er_track u_track (
    .clk(clk), .rst_n(rst_n), .wren_set(wren_set), .go(go),
    .done(erase_done), .wel(wel), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_start    <= 1'b0;
      erase_ignored  <= 1'b0;
      erase_rejected <= 1'b0;
      erase_addr     <= '0;
      erase_len      <= '0;
    end else begin
      erase_start    <= go;
      erase_ignored  <= ign;
      erase_rejected <= rej;
      if (go) begin
        erase_addr <= base;
        erase_len  <= span;
      end
    end
  end

endmodule

// File: rtl/er_resolver_chk.sv
module er_resolver_chk #(
  parameter int ADDR_W     = 24,
  parameter int ARRAY_LOG2 = 22,
  localparam int LEN_W     = ARRAY_LOG2 + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              go,
  input logic              erase_done,
  input logic              erase_start,
  input logic [ADDR_W-1:0] erase_addr,
  input logic [LEN_W-1:0]  erase_len,
  input logic              erase_ignored,
  input logic              erase_rejected,
  input logic              wel,
  input logic              busy
);

  logic [31:0] len_mask;
  assign len_mask = 32'(erase_len) - 32'd1;

  a_r8_start_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> $past(wel));

  a_r8_start_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> !wel);

  a_r9_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> busy);

  a_r9_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> !$past(busy));

  a_r9_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && erase_done) |=> !busy);

  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_start, erase_ignored, erase_rejected}));

  a_r11_go_latency: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> erase_start);

  a_r2_start_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> ((32'(erase_addr) & len_mask) == 32'd0));

  a_r7_whole_array_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_start && (32'(erase_len) == (32'd1 << ARRAY_LOG2))) |-> (erase_addr == '0));

endmodule

bind er_resolver er_resolver_chk #(.ADDR_W(ADDR_W), .ARRAY_LOG2(ARRAY_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .erase_done(erase_done),
  .erase_start(erase_start), .erase_addr(erase_addr), .erase_len(erase_len),
  .erase_ignored(erase_ignored), .erase_rejected(erase_rejected),
  .wel(wel), .busy(busy)
);

// File: tb/er_resolver_bench.sv
module er_resolver_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_opcode = 8'h00;
  logic [23:0] req_addr = 24'h0;
  logic        cfg_top_param = 1'b0;
  logic        cfg_param_en = 1'b0;
  logic        wren_set = 1'b0;
  logic        erase_done = 1'b0;
  logic        erase_start;
  logic [23:0] erase_addr;
  logic [22:0] erase_len;
  logic        erase_ignored;
  logic        erase_rejected;
  logic        wel;
  logic        busy;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  er_resolver u_er_resolver (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_addr(req_addr), .cfg_top_param(cfg_top_param), .cfg_param_en(cfg_param_en),
    .wren_set(wren_set), .erase_done(erase_done), .erase_start(erase_start),
    .erase_addr(erase_addr), .erase_len(erase_len), .erase_ignored(erase_ignored),
    .erase_rejected(erase_rejected), .wel(wel), .busy(busy)
  );

  function automatic logic [31:0] round_down(input logic [31:0] a, input logic [31:0] g);
    return a - (a % g);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wren();
    @(negedge clk) wren_set = 1'b1;
    @(negedge clk) wren_set = 1'b0;
  endtask

  task automatic issue(input logic [7:0] op, input logic [23:0] a, input bit top, input bit pen);
    @(negedge clk);
    req_opcode = op; req_addr = a; cfg_top_param = top; cfg_param_en = pen; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_go(input string req, input logic [31:0] a, input logic [31:0] len);
    chk(req, "erase_start", 32'(erase_start), 1);
    chk(req, "erase_addr", 32'(erase_addr), a);
    chk(req, "erase_len", 32'(erase_len), len);
    chk(req, "busy", 32'(busy), 1);
    chk("R8", "wel cleared by start", 32'(wel), 0);
    @(negedge clk);
    chk("R11", "start pulse width", 32'(erase_start), 0);
    chk("R11", "addr held", 32'(erase_addr), a);
  endtask

  task automatic expect_ign(input string req);
    chk(req, "erase_ignored", 32'(erase_ignored), 1);
    chk(req, "erase_start", 32'(erase_start), 0);
    chk(req, "wel kept", 32'(wel), 1);
  endtask

  task automatic expect_rej(input string req);
    chk(req, "erase_rejected", 32'(erase_rejected), 1);
    chk(req, "erase_start", 32'(erase_start), 0);
  endtask

  task automatic close_erase();
    @(negedge clk) erase_done = 1'b1;
    @(negedge clk) erase_done = 1'b0;
    chk("R9", "busy after done", 32'(busy), 0);
  endtask

  task automatic t_reset();
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "wel", 32'(wel), 0);
    chk("R1", "flags", {29'd0, erase_start, erase_ignored, erase_rejected}, 0);
  endtask

  task automatic t_block();
    wren(); issue(8'hD8, 24'h123456, 0, 0);
    expect_go("R2", round_down(32'h123456, 65536), 65536); close_erase();
    wren(); issue(8'hD8, 24'h3E3123, 1, 1);
    expect_go("R2", 32'h3E0000, 65536); close_erase();
  endtask

  task automatic t_small1();
    wren(); issue(8'h20, 24'h015A34, 0, 1);
    expect_go("R3", round_down(32'h015A34, 4096), 4096); close_erase();
  endtask

  task automatic t_small2();
    wren(); issue(8'h40, 24'h017FFF, 0, 1);
    expect_go("R4", 32'h016000, 8192); close_erase();
    wren(); issue(8'h40, 24'h011FFF, 0, 1);
    expect_go("R4", 32'h010000, 8192); close_erase();
  endtask

  task automatic t_place();
    wren(); issue(8'h20, 24'h3E3123, 1, 1);
    expect_go("R5", 32'h3E3000, 4096); close_erase();
    wren(); issue(8'h20, 24'h3E3123, 0, 1);
    expect_ign("R5");
    issue(8'h40, 24'h01F000, 0, 1);
    expect_go("R5", 32'h01E000, 8192); close_erase();
  endtask

  task automatic t_ignore();
    wren(); issue(8'h20, 24'h010000, 1, 1);
    expect_ign("R6");
    issue(8'h40, 24'h001000, 0, 0);
    expect_ign("R6");
    @(negedge clk);
    chk("R6", "no busy after ignore", 32'(busy), 0);
  endtask

  task automatic t_bulk();
    issue(8'hC7, 24'h3F0001, 1, 1);
    expect_go("R7", 0, 32'h400000); close_erase();
    wren(); issue(8'h60, 24'h123456, 0, 0);
    expect_go("R7", 0, 32'h400000); close_erase();
  endtask

  task automatic t_wel();
    chk("R8", "wel idle", 32'(wel), 0);
    issue(8'hD8, 24'h050000, 0, 0);
    expect_rej("R8");
    chk("R8", "addr unchanged", 32'(erase_addr), 0);
    wren();
    chk("R8", "wel set", 32'(wel), 1);
    issue(8'hD8, 24'h050000, 0, 0);
    expect_go("R8", 32'h050000, 65536); close_erase();
  endtask

  task automatic t_busy();
    wren(); issue(8'hD8, 24'h2A0000, 0, 0);
    expect_go("R9", 32'h2A0000, 65536);
    wren(); issue(8'h20, 24'h000000, 0, 1);
    expect_rej("R9");
    chk("R9", "busy held", 32'(busy), 1);
    close_erase();
    issue(8'h20, 24'h000000, 0, 1);
    expect_go("R9", 0, 4096); close_erase();
  endtask

  task automatic t_bad();
    wren(); issue(8'h55, 24'h000000, 0, 1);
    expect_rej("R10");
    issue(8'hD8, 24'h400000, 0, 0);
    expect_rej("R10");
    issue(8'h20, 24'hC00000, 0, 1);
    expect_rej("R10");
    chk("R10", "wel kept", 32'(wel), 1);
    chk("R10", "busy", 32'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_block();
    t_small1();
    t_small2();
    t_place();
    t_ignore();
    t_bulk();
    t_wel();
    t_busy();
    t_bad();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule